// File: doc/BRIEF.md
# Banked Register Window Decoder

This block sits between a host bus and a small peripheral register file. The register file is reached through a 16-byte I/O window of four 32-bit doublewords. A three-bit bank number chooses which of eight register banks the lower part of the window maps to. The bank number is held in a bank register, and that register stays reachable at the top of the window whatever bank is selected. The block decodes each access from the doubleword index, the byte enables and the current bank. From these it drives one-cycle write and read strobes for each banked byte.

One bank holds no internal registers. In that bank, accesses to the lower half of the window drive an active-low chip-select for logic outside the device. The block also assembles the read data for each access. It takes that data from the banked register file, from the external input, or from the bank register itself. The top byte of the bank register returns a fixed signature, so software can use it to find the device.

All outputs are registered. Strobes and the chip-select appear in the cycle after the access is sampled. Read data and its valid flag appear one cycle after that.

Top module: `bank_window_decoder`

## Requirements
- R1: After synchronous reset, the bank is 0, every strobe is low, `ext_cs_n` is high, `ext_we` is low and `rd_valid` is low.
- R2: A write to doubleword 3 with byte enable 2 set loads the bank from `acc_wdata[19:17]`. In the low byte of the bank register, bits 0 and 4..7 are not stored, and they always read 0. That low byte reads back in lane 2 of doubleword 3 as `{4'b0, bank, 1'b0}`.
- R3: Lane 3 of doubleword 3 always reads 8'h33, in every bank. Writes to that lane change nothing and raise no strobe.
- R4: A write to doubleword 3 with all four byte enables set updates the bank and raises no strobe for bytes 12 and 13.
- R5: In banks 0..6, a write to doubleword 3 that does not enable all four lanes strobes byte 12 and byte 13 for lanes 0 and 1 when those lanes are enabled.
- R6: In banks 0..6, a write raises `wr_stb[4*dw+lane]` for each enabled lane below the bank register, for exactly the one cycle after the access.
- R7: In banks 0..6, a read raises `rd_stb[4*dw+lane]` for each enabled lane below the bank register, for exactly the one cycle after the access.
- R8: In bank 7, an access to doubleword 0 or 1 (address bit 3 clear) drives `ext_cs_n` low for exactly the cycle after the access. `ext_we` follows the access direction, and no internal strobe fires.
- R9: In bank 7, accesses to doubleword 2 and to lanes 0..1 of doubleword 3 raise no strobe and no chip-select, and those lanes read 0.
- R10: Read data appears two cycles after the access, with `rd_valid` high for one cycle. Lanes of doublewords 0..2 come from `banked_rdata` in banks 0..6, and from `ext_rdata` in bank 7 when address bit 3 is clear. Lanes that are not enabled read 0.
- R11: The bank register can be read and written in every bank, including bank 7. `cur_bank` always shows the bank currently held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_dw | input | 2 | Doubleword index within the window (address bits 3:2) |
| acc_be | input | 4 | Byte enables, one per lane |
| acc_wdata | input | 32 | Write data |
| banked_rdata | input | 32 | Read data from the banked register file, sampled the cycle after the access |
| ext_rdata | input | 32 | Read data from external logic, sampled while `ext_cs_n` is low |
| rd_data | output | 32 | Assembled read data |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| wr_stb | output | 14 | Per-byte write strobes for bytes 0..13 |
| rd_stb | output | 14 | Per-byte read strobes for bytes 0..13 |
| out_wdata | output | 32 | Registered write data, aligned with the strobes |
| ext_cs_n | output | 1 | Active-low external chip-select |
| ext_we | output | 1 | Write flag that goes with the external chip-select |
| cur_bank | output | 3 | Currently selected bank |

## Verification
The bench targets the doubleword write at offset Ch. A decoder that treats that write as an ordinary write would strobe bytes 12 and 13, and would corrupt the bank's own registers there. It checks that writes carrying junk in the unused low-byte bits and in the signature lane leave only the three bank bits stored. A wrong design would read back those bits, or lose the 33h signature. In bank 7 it separates the lower half of the window, which must raise the chip-select and return external data, from the upper half, which must stay silent and read zero. It also checks that the chip-select lasts only one cycle. Byte-enable masking is checked on both strobes and read lanes, so a design that decoded whole doublewords would show extra strobe bits or non-zero disabled lanes.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  // where one read lane takes its byte from
  typedef enum logic [2:0] {
    SRC_NONE   = 3'd0,
    SRC_BANKED = 3'd1,
    SRC_EXT    = 3'd2,
    SRC_BSEL   = 3'd3,
    SRC_SIG    = 3'd4
  } lane_src_e;
endpackage

// File: rtl/bwd_bank_reg.sv
module bwd_bank_reg #(
  parameter int BANK_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_byte,
  output logic [BANK_W-1:0] bank,
  output logic [7:0]        rd_byte
);
  // bank bits live at byte positions BANK_W..1; the rest are constant zero
  always_ff @(posedge clk) begin
    if (rst)        bank <= '0;
    else if (wr_en) bank <= wr_byte[BANK_W:1];
  end

  always_comb begin
    rd_byte = '0;
    rd_byte[BANK_W:1] = bank;
  end
endmodule

// File: rtl/bwd_decode.sv
module bwd_decode
  import bwd_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int ADDR_W   = 2,
  parameter int BANK_W   = 3,
  parameter int NSTB     = 14,
  parameter int EXT_BANK = 7
) (
  input  logic                  valid,
  input  logic                  write,
  input  logic [ADDR_W-1:0]     dw,
  input  logic [LANES-1:0]      be,
  input  logic [BANK_W-1:0]     bank,
  output lane_src_e [LANES-1:0] lane_src,
  output logic [NSTB-1:0]       wr_stb,
  output logic [NSTB-1:0]       rd_stb,
  output logic                  ext_sel,
  output logic                  bsel_wr
);
  localparam int NDW = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] TOP_DW = ADDR_W'(NDW - 1);
  localparam logic [BANK_W-1:0] XB = BANK_W'(EXT_BANK);

  logic is_top, in_ext_bank, low_half, full_top_wr;

  assign is_top      = (dw == TOP_DW);
  assign in_ext_bank = (bank == XB);
  assign low_half    = ~dw[ADDR_W-1];
  assign full_top_wr = is_top & write & (&be);
  assign ext_sel     = valid & in_ext_bank & low_half;
  assign bsel_wr     = valid & write & is_top & be[LANES-2];

  // per-lane source selection
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_comb begin
      if (!be[l])                          lane_src[l] = SRC_NONE;
      else if (is_top && l == LANES-1)     lane_src[l] = SRC_SIG;
      else if (is_top && l == LANES-2)     lane_src[l] = SRC_BSEL;
      else if (in_ext_bank)                lane_src[l] = low_half ? SRC_EXT : SRC_NONE;
      else                                 lane_src[l] = SRC_BANKED;
    end
  end

  // per-byte strobes: byte index = dword*LANES + lane
  for (genvar d = 0; d < NDW; d++) begin : g_dw
    for (genvar l = 0; l < LANES; l++) begin : g_ln
      if (d * LANES + l < NSTB) begin : g_stb
        logic hit;
        assign hit = valid & (dw == ADDR_W'(d)) & (lane_src[l] == SRC_BANKED);
        assign wr_stb[d*LANES+l] = hit & write & ~full_top_wr;
        assign rd_stb[d*LANES+l] = hit & ~write;
      end
    end
  end
endmodule

// File: rtl/bwd_rd_return.sv
module bwd_rd_return
  import bwd_pkg::*;
#(
  parameter int       LANES = 4,
  parameter logic [7:0] SIG = 8'h33
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pend,
  input  lane_src_e [LANES-1:0] src,
  input  logic [7:0]            bsel_byte,
  input  logic [LANES*8-1:0]    banked_rdata,
  input  logic [LANES*8-1:0]    ext_rdata,
  output logic [LANES*8-1:0]    rd_data,
  output logic                  rd_valid
);
  logic [LANES*8-1:0] nxt;

  for (genvar l = 0; l < LANES; l++) begin : g_mux
    always_comb begin
      unique case (src[l])
        SRC_BANKED: nxt[l*8 +: 8] = banked_rdata[l*8 +: 8];
        SRC_EXT:    nxt[l*8 +: 8] = ext_rdata[l*8 +: 8];
        SRC_BSEL:   nxt[l*8 +: 8] = bsel_byte;
        SRC_SIG:    nxt[l*8 +: 8] = SIG;
        default:    nxt[l*8 +: 8] = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pend;
      if (pend) rd_data <= nxt;
    end
  end
endmodule

// File: rtl/bank_window_decoder.sv
module bank_window_decoder
  import bwd_pkg::*;
#(
  parameter int         DATA_W   = 32,
  parameter int         BANK_W   = 3,
  parameter int         WIN_DW   = 4,
  parameter int         EXT_BANK = 7,
  parameter logic [7:0] SIG      = 8'h33,
  localparam int        LANES    = DATA_W / 8,
  localparam int        ADDR_W   = $clog2(WIN_DW),
  localparam int        NSTB     = WIN_DW * LANES - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_dw,
  input  logic [LANES-1:0]  acc_be,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] banked_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [NSTB-1:0]   wr_stb,
  output logic [NSTB-1:0]   rd_stb,
  output logic [DATA_W-1:0] out_wdata,
  output logic              ext_cs_n,
  output logic              ext_we,
  output logic [BANK_W-1:0] cur_bank
);
  lane_src_e [LANES-1:0] src_d, src_q;
  logic [NSTB-1:0] wr_d, rd_d;
  logic            ext_sel, bsel_wr;
  logic [7:0]      bsel_byte, bsel_byte_q;
  logic            pend_q;

  bwd_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (bsel_wr),
    .wr_byte (acc_wdata[(LANES-2)*8 +: 8]),
    .bank    (cur_bank),
    .rd_byte (bsel_byte)
  );

  bwd_decode #(
    .LANES(LANES), .ADDR_W(ADDR_W), .BANK_W(BANK_W),
    .NSTB(NSTB), .EXT_BANK(EXT_BANK)
  ) u_dec (
    .valid    (acc_valid),
    .write    (acc_write),
    .dw       (acc_dw),
    .be       (acc_be),
    .bank     (cur_bank),
    .lane_src (src_d),
    .wr_stb   (wr_d),
    .rd_stb   (rd_d),
    .ext_sel  (ext_sel),
    .bsel_wr  (bsel_wr)
  );

  // stage 1: strobes, chip-select and read context
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_stb      <= '0;
      rd_stb      <= '0;
      ext_cs_n    <= 1'b1;
      ext_we      <= 1'b0;
      out_wdata   <= '0;
      pend_q      <= 1'b0;
      src_q       <= '{default: SRC_NONE};
      bsel_byte_q <= '0;
    end else begin
      wr_stb      <= wr_d;
      rd_stb      <= rd_d;
      ext_cs_n    <= ~ext_sel;
      ext_we      <= ext_sel & acc_write;
      pend_q      <= acc_valid & ~acc_write;
      if (acc_valid) begin
        out_wdata   <= acc_wdata;
        src_q       <= src_d;
        bsel_byte_q <= bsel_byte;
      end
    end
  end

  // stage 2: read data return
  bwd_rd_return #(.LANES(LANES), .SIG(SIG)) u_ret (
    .clk          (clk),
    .rst          (rst),
    .pend         (pend_q),
    .src          (src_q),
    .bsel_byte    (bsel_byte_q),
    .banked_rdata (banked_rdata),
    .ext_rdata    (ext_rdata),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int BANK_W = 3,
  parameter int ADDR_W = 2,
  parameter int LANES  = 4,
  parameter int NSTB   = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_dw,
  input logic [LANES-1:0]  acc_be,
  input logic [NSTB-1:0]   wr_stb,
  input logic [NSTB-1:0]   rd_stb,
  input logic              ext_cs_n,
  input logic              rd_valid,
  input logic [BANK_W-1:0] cur_bank
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  // R6: a write strobe only follows a write access
  a_r6_wr_follows_write: assert property (@(posedge clk) disable iff (rst)
    (|wr_stb) |-> $past(acc_valid && acc_write));

  // R7: a read strobe only follows a read access, at most one lane-set wide
  a_r7_rd_follows_read: assert property (@(posedge clk) disable iff (rst)
    (|rd_stb) |-> ($past(acc_valid && !acc_write) && $countones(rd_stb) <= LANES));

  // R8: chip-select only for the external bank's lower half, never with strobes
  a_r8_cs_source: assert property (@(posedge clk) disable iff (rst)
    !ext_cs_n |-> ($past(acc_valid && cur_bank == '1 && !acc_dw[ADDR_W-1])
                   && wr_stb == '0 && rd_stb == '0));

  // R4: a full doubleword write at the top never strobes bytes 12/13
  a_r4_full_top_quiet: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_write && acc_dw == TOP && acc_be == '1) |=> (wr_stb[NSTB-1:NSTB-2] == '0));

  // R2: the bank only changes after a write to its lane
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (rst)
    !(acc_valid && acc_write && acc_dw == TOP && acc_be[LANES-2]) |=> $stable(cur_bank));

  // R10: read data valid exactly two cycles after a read
  a_r10_rvalid_timing: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_write) |=> ##1 rd_valid);
endmodule

bind bank_window_decoder bwd_checker #(
  .BANK_W(BANK_W), .ADDR_W(ADDR_W), .LANES(LANES), .NSTB(NSTB)
) u_bwd_checker (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_write (acc_write),
  .acc_dw    (acc_dw),
  .acc_be    (acc_be),
  .wr_stb    (wr_stb),
  .rd_stb    (rd_stb),
  .ext_cs_n  (ext_cs_n),
  .rd_valid  (rd_valid),
  .cur_bank  (cur_bank)
);

// File: tb/test_bank_window_decoder.sv
module test_bank_window_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid, acc_write;
  logic [1:0]  acc_dw;
  logic [3:0]  acc_be;
  logic [31:0] acc_wdata;
  logic [31:0] banked_rdata, ext_rdata;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [13:0] wr_stb, rd_stb;
  logic [31:0] out_wdata;
  logic        ext_cs_n, ext_we;
  logic [2:0]  cur_bank;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  // sampled results of the last access
  logic [13:0] s_wr, s_rd;
  logic        s_csn, s_we, s_csn2, s_rv;
  logic [31:0] s_rdata;

  always #2 clk = ~clk;

  bank_window_decoder i_bank_window_decoder (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_dw(acc_dw), .acc_be(acc_be), .acc_wdata(acc_wdata),
    .banked_rdata(banked_rdata), .ext_rdata(ext_rdata),
    .rd_data(rd_data), .rd_valid(rd_valid), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .out_wdata(out_wdata), .ext_cs_n(ext_cs_n), .ext_we(ext_we), .cur_bank(cur_bank)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] dw, input logic [3:0] be,
                     input logic [31:0] wd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = w; acc_dw = dw; acc_be = be; acc_wdata = wd;
    @(negedge clk);
    acc_valid = 1'b0;
    s_wr = wr_stb; s_rd = rd_stb; s_csn = ext_cs_n; s_we = ext_we;
    @(negedge clk);
    s_csn2 = ext_cs_n; s_rv = rd_valid; s_rdata = rd_data;
  endtask

  task automatic set_bank(input logic [2:0] b);
    acc(1'b1, 2'd3, 4'b0100, {12'h0, b, 17'h0});
  endtask

  // {bank[23:21], dw[20:19], be[18:15], expected wr_stb[14:1], expected ext_cs_n[0]}
  localparam int NV = 11;
  localparam logic [23:0] VEC [NV] = '{
    {3'd0, 2'd0, 4'b1111, 14'h000F, 1'b1},  // R6
    {3'd2, 2'd1, 4'b0101, 14'h0050, 1'b1},  // R6
    {3'd5, 2'd2, 4'b1000, 14'h0800, 1'b1},  // R6
    {3'd6, 2'd3, 4'b0011, 14'h3000, 1'b1},  // R5
    {3'd3, 2'd3, 4'b1111, 14'h0000, 1'b1},  // R4
    {3'd7, 2'd0, 4'b0001, 14'h0000, 1'b0},  // R8
    {3'd7, 2'd1, 4'b1100, 14'h0000, 1'b0},  // R8
    {3'd7, 2'd2, 4'b1111, 14'h0000, 1'b1},  // R9
    {3'd7, 2'd3, 4'b0011, 14'h0000, 1'b1},  // R9
    {3'd1, 2'd3, 4'b0100, 14'h0000, 1'b1},  // R2
    {3'd4, 2'd3, 4'b1000, 14'h0000, 1'b1}   // R3
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog R1..R11 actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; acc_valid = 1'b0; acc_write = 1'b0; acc_dw = '0; acc_be = '0;
    acc_wdata = '0; banked_rdata = 32'hA1B2C3D4; ext_rdata = 32'h55667788;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 bank", 32'(cur_bank), 32'd0);
    chk("R1 strobes", {4'h0, wr_stb, rd_stb}, 32'h0);
    chk("R1 cs/we/rvalid", {29'h0, ext_cs_n, ext_we, rd_valid}, 32'h4);

    // vector table: write decoding across banks and lanes
    for (int i = 0; i < NV; i++) begin
      logic [2:0] b;
      b = VEC[i][23:21];
      set_bank(b);
      acc(1'b1, VEC[i][20:19], VEC[i][18:15], {12'h0, b, 17'h0});
      chk($sformatf("R6/R5/R4/R8/R9 vec%0d wr_stb", i), 32'(s_wr), 32'(VEC[i][14:1]));
      chk($sformatf("R8 vec%0d ext_cs_n", i), 32'(s_csn), 32'(VEC[i][0]));
      chk($sformatf("R11 vec%0d bank kept", i), 32'(cur_bank), 32'(b));
      chk($sformatf("R8 vec%0d cs one cycle", i), 32'(s_csn2), 32'd1);
    end

    // R2/R11: junk bits around the bank field, written while in bank 4
    acc(1'b1, 2'd3, 4'b0100, 32'hFFFF_FFFF);
    chk("R2 bank from bits 19:17", 32'(cur_bank), 32'd7);
    acc(1'b0, 2'd3, 4'b1100, 32'h0);
    chk("R2 R11 readback in bank 7", s_rdata, 32'h330E_0000);
    chk("R10 rd_valid", 32'(s_rv), 32'd1);

    // R3: signature lane write ignored
    acc(1'b1, 2'd3, 4'b1000, 32'h0000_0000);
    chk("R3 bank unchanged", 32'(cur_bank), 32'd7);
    acc(1'b0, 2'd3, 4'b1000, 32'h0);
    chk("R3 signature", s_rdata, 32'h3300_0000);

    // R4: full doubleword write updates bank only
    set_bank(3'd2);
    acc(1'b1, 2'd3, 4'b1111, 32'hFFF5_FFFF);
    chk("R4 no strobe 12/13", 32'(s_wr), 32'h0);
    chk("R4 bank updated", 32'(cur_bank), 32'd2);
    acc(1'b1, 2'd3, 4'b1111, {12'h0, 3'd5, 17'h0});
    chk("R4 bank updated to 5", 32'(cur_bank), 32'd5);
    acc(1'b0, 2'd3, 4'b1111, 32'h0);
    chk("R4 R10 top dword read", s_rdata, 32'h330A_C3D4);
    chk("R7 rd strobes 12/13", 32'(s_rd), 32'h3000);

    // R7/R10: masked read in a normal bank
    acc(1'b0, 2'd1, 4'b0110, 32'h0);
    chk("R7 rd strobes", 32'(s_rd), 32'h0060);
    chk("R10 masked lanes", s_rdata, 32'h00B2_C300);

    // R8/R10: external read in bank 7
    set_bank(3'd7);
    acc(1'b0, 2'd0, 4'b1111, 32'h0);
    chk("R8 cs low", 32'(s_csn), 32'd0);
    chk("R8 we low on read", 32'(s_we), 32'd0);
    chk("R8 no rd strobes", 32'(s_rd), 32'h0);
    chk("R10 external data", s_rdata, 32'h5566_7788);
    acc(1'b1, 2'd1, 4'b0001, 32'h0);
    chk("R8 we high on write", 32'(s_we), 32'd1);

    // R9: upper half of bank 7 is silent
    acc(1'b0, 2'd2, 4'b1111, 32'h0);
    chk("R9 no cs", 32'(s_csn), 32'd1);
    chk("R9 reads zero", s_rdata, 32'h0);
    acc(1'b0, 2'd3, 4'b1111, 32'h0);
    chk("R9 R11 top dword in bank 7", s_rdata, 32'h330E_0000);

    // R1: reset again returns bank to 0
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1 bank after reset", 32'(cur_bank), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule